// File: doc/BRIEF.md
# Microprogrammed Sequencer with Register-Indirect Datapath

This block is a small programmable engine that starts from a microcode sequencer and adds a datapath. A program counter addresses an internal instruction store. Each instruction either steers the program counter with a conditional jump, sets a general register to an immediate value, or operates on three 8-bit registers (A0, A1, ACC) and an internal 256-word data memory through the address A1 + A0.

Both arrays have no contents after power-up. They are filled through a single write port while `rst` is high. When reset is released, execution begins at address 0 and one instruction completes on every clock edge. Two external condition lines and a flag that is set when ACC is non-zero can be tested by jumps. The data memory can be read at any time through a separate observation port.

Top module: `mseq_proc`

## Requirements
- R1: An instruction word is 14 bits wide: opcode in [13:11], selector field in [10:8], value in [7:0]. Opcodes 101, 110 and 111 change no register and no memory word, and the program counter advances by one.
- R2: Opcode 010 (add) writes ACC with (A1 + A0) mod 256 at the clock edge.
- R3: Opcode 011 (load) writes ACC with the data memory word at address (A1 + A0) mod 256. The read is combinational, so a word stored by an earlier instruction is returned.
- R4: Opcode 100 (store) writes ACC into the data memory at address (A1 + A0) mod 256 at the clock edge. A0, A1 and ACC are unchanged.
- R5: Opcode 001 (set) writes the value field into the register chosen by the selector: 0 selects A0, 1 selects A1, 2 selects ACC. Selector values 3 to 7 change no register.
- R6: Opcode 000 (jump) tests a condition chosen by selector bits [1:0]: 00 picks `cond_in[0]`, 01 picks `cond_in[1]`, 10 is always true, and 11 is ACC non-zero. Selector bit [2] inverts the result.
- R7: When a jump condition holds, the program counter is loaded with the value field. In every other case it becomes (pc + 1) mod 256.
- R8: While `rst` is high, the program counter and A0, A1 and ACC are held at 0. In that state, `ld_en` writes `ld_data` to the instruction store (`ld_sel`=0) or writes `ld_data[7:0]` to the data memory (`ld_sel`=1) at `ld_addr`. When `rst` is low, `ld_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset and load-mode enable, active high |
| ld_en | input | 1 | Loader write strobe, used only during reset |
| ld_sel | input | 1 | Loader target: 0 instruction store, 1 data memory |
| ld_addr | input | 8 | Loader write address |
| ld_data | input | 14 | Loader write data (data memory uses bits [7:0]) |
| cond_in | input | 2 | External conditions tested by jumps |
| peek_addr | input | 8 | Data memory observation address |
| peek_data | output | 8 | Combinational data memory word at `peek_addr` |
| pc_o | output | 8 | Program counter |
| a0_o | output | 8 | Register A0 |
| a1_o | output | 8 | Register A1 |
| acc_o | output | 8 | Register ACC |

## Verification
The assertions assume that `rst` is high in the first clock cycle, so that the program counter and registers start from known values. They also assume that `cond_in` is stable near the rising edge. The bench changes `cond_in` and every loader input only on falling edges. It asserts reset before it loads anything. It also pulses `ld_en` for both targets once reset has been released, so that the rule that loads are ignored outside reset is exercised.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int OPW = 3;
  localparam int SELW = 3;

  localparam logic [OPW-1:0] OP_JMP   = 3'b000;
  localparam logic [OPW-1:0] OP_SET   = 3'b001;
  localparam logic [OPW-1:0] OP_ADD   = 3'b010;
  localparam logic [OPW-1:0] OP_LOAD  = 3'b011;
  localparam logic [OPW-1:0] OP_STORE = 3'b100;

  localparam logic [1:0] CND_IN0  = 2'b00;
  localparam logic [1:0] CND_IN1  = 2'b01;
  localparam logic [1:0] CND_ONE  = 2'b10;
  localparam logic [1:0] CND_ACCZ = 2'b11;
endpackage

// File: rtl/mseq_istore.sv
module mseq_istore #(
  parameter int AW = 8,
  parameter int IW = 14
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [IW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [IW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [IW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) words[wr_addr] <= wr_data;
  end

  assign rd_data = words[rd_addr];
endmodule

// File: rtl/mseq_dmem.sv
module mseq_dmem #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [DW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] paddr,
  output logic [DW-1:0] pdata
);
  localparam int DEPTH = 1 << DW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
  assign pdata = cells[paddr];
endmodule

// File: rtl/mseq_branch.sv
module mseq_branch
  import mseq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            is_jmp,
  input  logic [SELW-1:0] sel,
  input  logic [DW-1:0]   target,
  input  logic [DW-1:0]   pc,
  input  logic [1:0]      cond_in,
  input  logic            acc_nz,
  output logic            taken,
  output logic [DW-1:0]   next_pc
);
  function automatic logic pick_cond(input logic [1:0] code, input logic [1:0] ext,
                                     input logic nz);
    case (code)
      CND_IN0:  return ext[0];
      CND_IN1:  return ext[1];
      CND_ONE:  return 1'b1;
      default:  return nz;
    endcase
  endfunction

  function automatic logic [DW-1:0] step(input logic [DW-1:0] p);
    return p + {{(DW-1){1'b0}}, 1'b1};
  endfunction

  logic raw_cond;

  assign raw_cond = pick_cond(sel[1:0], cond_in, acc_nz);
  assign taken    = is_jmp && (raw_cond ^ sel[SELW-1]);
  assign next_pc  = taken ? target : step(pc);

  // R6: only a jump instruction may redirect the sequence
  p_taken_needs_jmp_r6: assert property (@(posedge clk) disable iff (rst)
    taken |-> is_jmp);
  // R6: the always-true code without inversion redirects every time
  p_always_taken_r6: assert property (@(posedge clk) disable iff (rst)
    (is_jmp && sel == 3'b010) |-> taken);
endmodule

// File: rtl/mseq_regs.sv
module mseq_regs #(
  parameter int DW   = 8,
  parameter int SW   = 3,
  parameter int NREG = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_en,
  input  logic [SW-1:0]   set_sel,
  input  logic [DW-1:0]   set_val,
  input  logic            acc_en,
  input  logic [DW-1:0]   acc_val,
  output logic [NREG*DW-1:0] regs_o,
  output logic [NREG-1:0] we_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] q;
    logic          we;
    logic [DW-1:0] wd;

    if (i == NREG - 1) begin : g_acc
      assign we = (set_en && set_sel == SW'(i)) || acc_en;
      assign wd = acc_en ? acc_val : set_val;
    end else begin : g_plain
      assign we = set_en && set_sel == SW'(i);
      assign wd = set_val;
    end

    always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (we) q <= wd;
    end

    assign regs_o[i*DW +: DW] = q;
    assign we_o[i] = we;
  end

  // R5: a single instruction writes at most one register
  p_one_writer_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we_o));
  // R5: selectors beyond the register count touch nothing
  p_set_out_of_range_r5: assert property (@(posedge clk) disable iff (rst)
    (set_en && set_sel >= SW'(NREG) && !acc_en) |-> (we_o == '0));
endmodule

// File: rtl/mseq_proc.sv
module mseq_proc
  import mseq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_en,
  input  logic                 ld_sel,
  input  logic [DW-1:0]        ld_addr,
  input  logic [OPW+SELW+DW-1:0] ld_data,
  input  logic [1:0]           cond_in,
  input  logic [DW-1:0]        peek_addr,
  output logic [DW-1:0]        peek_data,
  output logic [DW-1:0]        pc_o,
  output logic [DW-1:0]        a0_o,
  output logic [DW-1:0]        a1_o,
  output logic [DW-1:0]        acc_o
);
  localparam int IW   = OPW + SELW + DW;
  localparam int NREG = 3;

  function automatic logic [DW-1:0] ea_sum(input logic [DW-1:0] b, input logic [DW-1:0] o);
    return b + o;
  endfunction

  logic [DW-1:0]      pc_q;
  logic [IW-1:0]      instr;
  logic [OPW-1:0]     op;
  logic [SELW-1:0]    sel;
  logic [DW-1:0]      val;
  logic [NREG*DW-1:0] regs;
  logic [NREG-1:0]    reg_we;
  logic [DW-1:0]      a0, a1, acc;
  logic [DW-1:0]      ea, mem_rd;
  logic               jmp_ev, set_ev, add_ev, load_ev, store_ev, idle_ev;
  logic               taken;
  logic [DW-1:0]      next_pc;
  logic               dm_we;
  logic [DW-1:0]      dm_waddr, dm_wdata;

  assign op  = instr[IW-1 -: OPW];
  assign sel = instr[DW+SELW-1 -: SELW];
  assign val = instr[DW-1:0];

  assign a0  = regs[0*DW +: DW];
  assign a1  = regs[1*DW +: DW];
  assign acc = regs[2*DW +: DW];
  assign ea  = ea_sum(a1, a0);

  assign jmp_ev   = !rst && op == OP_JMP;
  assign set_ev   = !rst && op == OP_SET;
  assign add_ev   = !rst && op == OP_ADD;
  assign load_ev  = !rst && op == OP_LOAD;
  assign store_ev = !rst && op == OP_STORE;
  assign idle_ev  = !rst && op > OP_STORE;

  mseq_istore #(.AW(DW), .IW(IW)) u_istore (
    .clk     (clk),
    .wr_en   (rst && ld_en && !ld_sel),
    .wr_addr (ld_addr),
    .wr_data (ld_data),
    .rd_addr (pc_q),
    .rd_data (instr)
  );

  assign dm_we    = rst ? (ld_en && ld_sel) : store_ev;
  assign dm_waddr = rst ? ld_addr : ea;
  assign dm_wdata = rst ? ld_data[DW-1:0] : acc;

  mseq_dmem #(.DW(DW)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (ea),
    .rdata (mem_rd),
    .paddr (peek_addr),
    .pdata (peek_data)
  );

  mseq_regs #(.DW(DW), .SW(SELW), .NREG(NREG)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .set_en  (set_ev),
    .set_sel (sel),
    .set_val (val),
    .acc_en  (add_ev || load_ev),
    .acc_val (add_ev ? ea : mem_rd),
    .regs_o  (regs),
    .we_o    (reg_we)
  );

  mseq_branch #(.DW(DW)) u_branch (
    .clk     (clk),
    .rst     (rst),
    .is_jmp  (jmp_ev),
    .sel     (sel),
    .target  (val),
    .pc      (pc_q),
    .cond_in (cond_in),
    .acc_nz  (acc != '0),
    .taken   (taken),
    .next_pc (next_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= next_pc;
  end

  assign pc_o  = pc_q;
  assign a0_o  = a0;
  assign a1_o  = a1;
  assign acc_o = acc;

  // R7: no redirect means the counter steps by one
  p_pc_step_r7: assert property (@(posedge clk) disable iff (rst)
    !taken |=> pc_q == DW'($past(pc_q) + 1'b1));
  // R7: a redirect lands on the value field
  p_pc_jump_r7: assert property (@(posedge clk) disable iff (rst)
    taken |=> pc_q == $past(val));
  // R4: a store leaves every register alone
  p_store_keeps_regs_r4: assert property (@(posedge clk) disable iff (rst)
    store_ev |=> $stable(regs));
  // R1: unassigned opcodes leave every register alone
  p_idle_keeps_regs_r1: assert property (@(posedge clk) disable iff (rst)
    idle_ev |=> $stable(regs));
  // R2: the sum of the address registers lands in ACC
  p_add_result_r2: assert property (@(posedge clk) disable iff (rst)
    add_ev |=> acc_o == DW'($past(a1_o) + $past(a0_o)));
  // R5: a set to the first register moves the value field there
  p_set_a0_r5: assert property (@(posedge clk) disable iff (rst)
    (set_ev && sel == 3'd0) |=> a0_o == $past(val));
endmodule

// File: tb/mseq_proc_bench.sv
module mseq_proc_bench;
  localparam int DW = 8;
  localparam int IW = 14;
  localparam int RUN_CYCLES = 120;

  logic          clk = 1'b0;
  logic          rst;
  logic          ld_en, ld_sel;
  logic [DW-1:0] ld_addr;
  logic [IW-1:0] ld_data;
  logic [1:0]    cond_in;
  logic [DW-1:0] peek_addr, peek_data;
  logic [DW-1:0] pc_o, a0_o, a1_o, acc_o;

  always #2 clk = ~clk;

  mseq_proc #(.DW(DW)) u_mseq_proc (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .cond_in(cond_in), .peek_addr(peek_addr),
    .peek_data(peek_data), .pc_o(pc_o), .a0_o(a0_o), .a1_o(a1_o), .acc_o(acc_o)
  );

  typedef struct {
    logic [DW-1:0] pc;
    logic [DW-1:0] r0;
    logic [DW-1:0] r1;
    logic [DW-1:0] r2;
    string         tag;
  } exp_t;

  exp_t          sb_q[$];
  int            n_chk = 0;
  int            n_bad = 0;
  logic [IW-1:0] prog [256];
  logic [DW-1:0] mem  [256];
  logic [DW-1:0] m_pc;
  logic [DW-1:0] m_r [3];
  logic [7:0]    lfsr = 8'hB5;
  bit            finished = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] got, input logic [DW-1:0] want);
    n_chk++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, want);
    end
  endtask

  function automatic logic [IW-1:0] enc(input logic [2:0] op, input logic [2:0] s,
                                        input logic [7:0] v);
    return {op, s, v};
  endfunction

  // reference step written from the requirements
  task automatic model_step(input logic [1:0] c, output string tag);
    logic [IW-1:0] w;
    logic [2:0]    op, s;
    logic [7:0]    v, addr;
    logic          hit;
    w = prog[m_pc];
    op = w[13:11]; s = w[10:8]; v = w[7:0];
    addr = m_r[1] + m_r[0];
    tag = "R1";
    case (op)
      3'd0: begin
        tag = "R6";
        unique case (s[1:0])
          2'd0: hit = c[0];
          2'd1: hit = c[1];
          2'd2: hit = 1'b1;
          default: hit = (m_r[2] != 0);
        endcase
        if (s[2]) hit = !hit;
        m_pc = hit ? v : m_pc + 8'd1;
      end
      3'd1: begin
        tag = "R5";
        if (s < 3'd3) m_r[s] = v;
        m_pc = m_pc + 8'd1;
      end
      3'd2: begin tag = "R2"; m_r[2] = addr; m_pc = m_pc + 8'd1; end
      3'd3: begin tag = "R3"; m_r[2] = mem[addr]; m_pc = m_pc + 8'd1; end
      3'd4: begin tag = "R4"; mem[addr] = m_r[2]; m_pc = m_pc + 8'd1; end
      default: m_pc = m_pc + 8'd1;
    endcase
  endtask

  task automatic drive_load(input logic sel_t, input logic [7:0] a, input logic [IW-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel_t; ld_addr = a; ld_data = d;
  endtask

  // monitor: compares outputs just after each edge against queued expectations
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check("R7", "pc", pc_o, e.pc);
        check(e.tag, "a0", a0_o, e.r0);
        check(e.tag, "a1", a1_o, e.r1);
        check(e.tag, "acc", acc_o, e.r2);
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ld_en = 1'b0; ld_sel = 1'b0; ld_addr = '0; ld_data = '0;
    cond_in = 2'b00; peek_addr = '0;

    for (int i = 0; i < 256; i++) begin
      prog[i] = enc(3'd0, 3'd6, 8'd0);
      mem[i]  = 8'(i * 7 + 3);
    end
    mem[8'h35] = 8'hA7;
    mem[8'h10] = 8'h4B;
    mem[8'h90] = 8'h3C;

    prog[0]  = enc(3'd1, 3'd0, 8'h05);
    prog[1]  = enc(3'd1, 3'd1, 8'h10);
    prog[2]  = enc(3'd2, 3'd5, 8'hFF);
    prog[3]  = enc(3'd4, 3'd0, 8'h00);
    prog[4]  = enc(3'd1, 3'd2, 8'h00);
    prog[5]  = enc(3'd3, 3'd0, 8'h00);
    prog[6]  = enc(3'd1, 3'd1, 8'h30);
    prog[7]  = enc(3'd3, 3'd0, 8'h00);
    prog[8]  = enc(3'd1, 3'd3, 8'hFF);
    prog[9]  = enc(3'd1, 3'd7, 8'h11);
    prog[10] = enc(3'd5, 3'd0, 8'h00);
    prog[11] = enc(3'd7, 3'd2, 8'h02);
    prog[12] = enc(3'd1, 3'd0, 8'h20);
    prog[13] = enc(3'd1, 3'd1, 8'hF0);
    prog[14] = enc(3'd2, 3'd0, 8'h00);
    prog[15] = enc(3'd3, 3'd0, 8'h00);
    prog[16] = enc(3'd0, 3'd3, 8'd18);
    prog[17] = enc(3'd1, 3'd2, 8'hEE);
    prog[18] = enc(3'd1, 3'd2, 8'h00);
    prog[19] = enc(3'd0, 3'd7, 8'd21);
    prog[20] = enc(3'd1, 3'd0, 8'h99);
    prog[21] = enc(3'd0, 3'd6, 8'd0);
    prog[22] = enc(3'd0, 3'd0, 8'd25);
    prog[23] = enc(3'd1, 3'd2, 8'h01);
    prog[24] = enc(3'd0, 3'd2, 8'd26);
    prog[25] = enc(3'd1, 3'd2, 8'h02);
    prog[26] = enc(3'd0, 3'd5, 8'd28);
    prog[27] = enc(3'd4, 3'd0, 8'h00);
    prog[28] = enc(3'd0, 3'd4, 8'd30);
    prog[29] = enc(3'd1, 3'd1, 8'h40);
    prog[30] = enc(3'd0, 3'd1, 8'd22);
    prog[31] = enc(3'd6, 3'd0, 8'h00);
    prog[32] = enc(3'd0, 3'd2, 8'd22);

    // R8: loading happens only while reset is held
    for (int i = 0; i < 256; i++) drive_load(1'b0, 8'(i), prog[i]);
    for (int i = 0; i < 256; i++) drive_load(1'b1, 8'(i), {6'd0, mem[i]});
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
    check("R8", "reset pc", pc_o, 8'h00);
    check("R8", "reset a0", a0_o, 8'h00);
    check("R8", "reset a1", a1_o, 8'h00);
    check("R8", "reset acc", acc_o, 8'h00);

    m_pc = 0; m_r[0] = 0; m_r[1] = 0; m_r[2] = 0;
    rst = 1'b0;

    // driver: one expectation per edge, stimulus changes on falling edges
    for (int n = 0; n < RUN_CYCLES; n++) begin
      string t;
      exp_t  e;
      if (n != 0) @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cond_in = lfsr[1:0];
      // R8: loader strobes after reset must be ignored
      ld_en = (n == 40 || n == 41);
      ld_sel = (n == 40);
      ld_addr = (n == 40) ? 8'h90 : 8'd22;
      ld_data = (n == 40) ? 14'h00EE : enc(3'd0, 3'd2, 8'd0);
      model_step(cond_in, t);
      e.pc = m_pc; e.r0 = m_r[0]; e.r1 = m_r[1]; e.r2 = m_r[2]; e.tag = t;
      sb_q.push_back(e);
    end
    @(negedge clk);
    ld_en = 1'b0;
    rst = 1'b1;

    // R4: memory image after the run, including the word the strobe aimed at (R8)
    for (int i = 0; i < 256; i++) begin
      peek_addr = 8'(i);
      #1;
      check((i == 8'h90) ? "R8" : "R4", "mem", peek_data, mem[i]);
    end
    // R3: stored word read back by a later load, held in memory
    peek_addr = 8'h15;
    #1;
    check("R3", "mem 15", peek_data, 8'h15);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule